// File: doc/BRIEF.md
# Unaligned Word Load/Store Byte-Lane Merger

This block performs the partial-word merge for the four unaligned word transfers of a 32-bit little-endian load/store path. Two of these transfers are loads and two are stores. Each has a "left" (high-part) form and a "right" (low-part) form. A single operation is presented with a kind code, an effective address and the current register value. The block always fetches the aligned word, which is the effective address with its low two bits cleared. How bytes combine is decided by the byte offset, which is the low two address bits.

For a load, the fetched word is shifted and the register bytes it does not cover are kept. The result is returned with a one-cycle register write strobe. For a store, the register value is shifted into the fetched word and the lanes it does not cover are left alone. The combined word is then written back to the same aligned address. A small sequencer handles the memory side. It holds a read request until the read is acknowledged, and for stores it then holds a write request until the write is acknowledged. No offset is ever treated as a misalignment fault.

Top module: `unaligned_merge_unit`

## Requirements
- R1: Every read and every write goes to the aligned address: the value of `op_addr` captured at acceptance, with its low two bits forced to zero. A store writes back to the same address it read.
- R2: Load-left (kind 2'b00), offset o: the result takes memory bytes 0..o into register bytes 3-o..3. Register bytes below 3-o keep their old value.
- R3: Load-right (kind 2'b01), offset o: the result takes memory bytes o..3 into register bytes 0..3-o. Register bytes above 3-o keep their old value.
- R4: Store-left (kind 2'b10), offset o: the written word carries register bytes 3-o..3 in memory bytes 0..o. Memory bytes above o are unchanged.
- R5: Store-right (kind 2'b11), offset o: the written word carries register bytes 0..3-o in memory bytes o..3. Memory bytes below o are unchanged.
- R6: A store issues exactly one read and then exactly one write. Each request stays asserted, with stable address and data, until its acknowledge. The two requests are never asserted together.
- R7: A load raises no write request. It pulses `reg_we` for exactly one cycle, in the cycle after the cycle in which `rd_ack` is sampled high, and `reg_wdata` carries the merged result in that cycle.
- R8: During and right after reset the block is idle: `op_ready` is 1, and `rd_req`, `wr_req` and `reg_we` are 0.
- R9: `op_ready` is low from acceptance until the operation finishes. `op_valid` asserted while busy is ignored and starts no extra transfer.
- R10: All four byte offsets of every kind complete normally. Kind, address and register value are captured at acceptance, and later changes on those inputs do not affect the operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request, taken when `op_ready` is high |
| op_ready | output | 1 | Block idle and able to accept |
| op_kind | input | 2 | 00 load-left, 01 load-right, 10 store-left, 11 store-right |
| op_addr | input | 32 | Effective byte address |
| op_reg | input | 32 | Current register value |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 32 | Aligned read address |
| rd_ack | input | 1 | Read acknowledge, `rd_data` valid with it |
| rd_data | input | 32 | Read data |
| wr_req | output | 1 | Memory write request |
| wr_addr | output | 32 | Aligned write address |
| wr_data | output | 32 | Merged store word |
| wr_ack | input | 1 | Write acknowledge |
| reg_we | output | 1 | One-cycle register write strobe for loads |
| reg_wdata | output | 32 | Merged load result |

## Verification
The bench sweeps every kind across all four offsets, because the two edge offsets are where the shift rules invert. If the left and right shift amounts were swapped, offsets 0 and 3 would move the whole word the wrong way and offsets 1 and 2 would mix lanes. It also varies the read and write acknowledge latency. A sequencer that stopped waiting for an acknowledge would then drop a request early, and one that misclassified a kind would raise a write for a load. Finally, it holds `op_valid` high and changes the operand inputs while the block is busy. A design that re-sampled those inputs would then produce a second read or a result built from the wrong operands.

// File: rtl/umg_pkg.sv
`timescale 1ns/1ps
package umg_pkg;

    // bit 1 selects store, bit 0 selects the right (low-part) form
    typedef enum logic [1:0] {
        K_LOAD_HI  = 2'b00,
        K_LOAD_LO  = 2'b01,
        K_STORE_HI = 2'b10,
        K_STORE_LO = 2'b11
    } merge_kind_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_READ  = 2'd1,
        S_WRITE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/umg_lane_merge.sv
`timescale 1ns/1ps
module umg_lane_merge #(
    parameter int DATA_W   = 32,
    parameter int OFS_W    = 2,
    parameter bit IS_STORE = 1'b0
) (
    input  logic              from_right,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] mem_word,
    input  logic [DATA_W-1:0] reg_word,
    output logic [DATA_W-1:0] merged
);
    localparam int SH_W  = OFS_W + 3;
    localparam int LANES = DATA_W / 8;
    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    logic [SH_W-1:0] sh_left;
    logic [SH_W-1:0] sh_right;

    // left form counts lanes from the top, right form from the bottom
    assign sh_left  = {ofs ^ OFS_W'(LANES - 1), 3'b000};
    assign sh_right = {ofs, 3'b000};

    generate
        if (IS_STORE) begin : g_store
            always_comb begin
                if (from_right)
                    merged = (mem_word & ~(ALL_ONES << sh_right)) | (reg_word << sh_right);
                else
                    merged = (mem_word & ~(ALL_ONES >> sh_left)) | (reg_word >> sh_left);
            end
        end else begin : g_load
            always_comb begin
                if (from_right)
                    merged = (mem_word >> sh_right) | (reg_word & ~(ALL_ONES >> sh_right));
                else
                    merged = (mem_word << sh_left) | (reg_word & ~(ALL_ONES << sh_left));
            end
        end
    endgenerate

endmodule

// File: rtl/umg_seq.sv
`timescale 1ns/1ps
module umg_seq
    import umg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic [1:0]        op_kind,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_reg,
    output logic [1:0]        cap_kind,
    output logic [OFS_W-1:0]  cap_ofs,
    output logic [DATA_W-1:0] cap_reg,
    input  logic [DATA_W-1:0] ld_merged,
    input  logic [DATA_W-1:0] st_merged,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ack,
    output logic              reg_we,
    output logic [DATA_W-1:0] reg_wdata
);
    typedef struct packed {
        seq_state_e        st;
        merge_kind_e       kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] word;   // operand, then merged result
        logic              we;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d    = seq_q;
        seq_d.we = 1'b0;
        unique case (seq_q.st)
            S_IDLE: begin
                if (op_valid) begin
                    seq_d.st   = S_READ;
                    seq_d.kind = merge_kind_e'(op_kind);
                    seq_d.addr = op_addr;
                    seq_d.word = op_reg;
                end
            end
            S_READ: begin
                if (rd_ack) begin
                    if (seq_q.kind[1]) begin
                        seq_d.word = st_merged;
                        seq_d.st   = S_WRITE;
                    end else begin
                        seq_d.word = ld_merged;
                        seq_d.we   = 1'b1;
                        seq_d.st   = S_IDLE;
                    end
                end
            end
            S_WRITE: begin
                if (wr_ack) seq_d.st = S_IDLE;
            end
            default: seq_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st   <= S_IDLE;
            seq_q.kind <= K_LOAD_HI;
            seq_q.addr <= '0;
            seq_q.word <= '0;
            seq_q.we   <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    logic [ADDR_W-1:0] aligned_addr;
    assign aligned_addr = {seq_q.addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};

    assign op_ready  = (seq_q.st == S_IDLE);
    assign cap_kind  = seq_q.kind;
    assign cap_ofs   = seq_q.addr[OFS_W-1:0];
    assign cap_reg   = seq_q.word;
    assign rd_req    = (seq_q.st == S_READ);
    assign rd_addr   = aligned_addr;
    assign wr_req    = (seq_q.st == S_WRITE);
    assign wr_addr   = aligned_addr;
    assign wr_data   = seq_q.word;
    assign reg_we    = seq_q.we;
    assign reg_wdata = seq_q.word;

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr))); // R6
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data))); // R6
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req)); // R6
    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_req) |-> ($past(rd_req && rd_ack) && wr_addr == $past(rd_addr))); // R1
    AST_WE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> ($past(rd_req && rd_ack) && !wr_req)); // R7
    AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we); // R7
    AST_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req || wr_req) |-> !op_ready); // R9

endmodule

// File: rtl/unaligned_merge_unit.sv
`timescale 1ns/1ps
module unaligned_merge_unit #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic [1:0]        op_kind,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_reg,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ack,
    output logic              reg_we,
    output logic [DATA_W-1:0] reg_wdata
);
    localparam int LANES = DATA_W / 8;
    localparam int OFS_W = $clog2(LANES);

    logic [1:0]        cap_kind;
    logic [OFS_W-1:0]  cap_ofs;
    logic [DATA_W-1:0] cap_reg;
    logic [DATA_W-1:0] ld_merged;
    logic [DATA_W-1:0] st_merged;

    umg_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_ready  (op_ready),
        .op_kind   (op_kind),
        .op_addr   (op_addr),
        .op_reg    (op_reg),
        .cap_kind  (cap_kind),
        .cap_ofs   (cap_ofs),
        .cap_reg   (cap_reg),
        .ld_merged (ld_merged),
        .st_merged (st_merged),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .rd_ack    (rd_ack),
        .wr_req    (wr_req),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_ack    (wr_ack),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata)
    );

    umg_lane_merge #(.DATA_W(DATA_W), .OFS_W(OFS_W), .IS_STORE(1'b0)) u_ld_merge (
        .from_right (cap_kind[0]),
        .ofs        (cap_ofs),
        .mem_word   (rd_data),
        .reg_word   (cap_reg),
        .merged     (ld_merged)
    );

    umg_lane_merge #(.DATA_W(DATA_W), .OFS_W(OFS_W), .IS_STORE(1'b1)) u_st_merge (
        .from_right (cap_kind[0]),
        .ofs        (cap_ofs),
        .mem_word   (rd_data),
        .reg_word   (cap_reg),
        .merged     (st_merged)
    );

endmodule

// File: tb/sim_unaligned_merge_unit.sv
`timescale 1ns/1ps
module sim_unaligned_merge_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_ready;
    logic [1:0]  op_kind = 2'b00;
    logic [31:0] op_addr = '0;
    logic [31:0] op_reg = '0;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic        rd_ack = 1'b0;
    logic [31:0] rd_data = '0;
    logic        wr_req;
    logic [31:0] wr_addr;
    logic [31:0] wr_data;
    logic        wr_ack = 1'b0;
    logic        reg_we;
    logic [31:0] reg_wdata;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    unaligned_merge_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .op_valid(op_valid), .op_ready(op_ready), .op_kind(op_kind),
        .op_addr(op_addr), .op_reg(op_reg),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
        .reg_we(reg_we), .reg_wdata(reg_wdata)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_at(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A0F_C3E1;
    endfunction

    // byte-by-byte reference of the four merges
    function automatic logic [31:0] ref_merge(input logic [1:0] k, input int o,
                                              input logic [31:0] mem, input logic [31:0] r);
        logic [31:0] res;
        for (int i = 0; i < 4; i++) begin
            case (k)
                2'b00: res[8*i +: 8] = (i >= 3 - o) ? mem[8*(i-(3-o)) +: 8] : r[8*i +: 8];
                2'b01: res[8*i +: 8] = (i <= 3 - o) ? mem[8*(i+o) +: 8]     : r[8*i +: 8];
                2'b10: res[8*i +: 8] = (i <= o)     ? r[8*(i+3-o) +: 8]     : mem[8*i +: 8];
                default: res[8*i +: 8] = (i >= o)   ? r[8*(i-o) +: 8]       : mem[8*i +: 8];
            endcase
        end
        return res;
    endfunction

    task automatic run_op(input logic [1:0] k, input logic [31:0] a, input logic [31:0] r,
                          input int rlat, input int wlat, input bit poke);
        logic [31:0] al;
        logic [31:0] mw;
        logic [31:0] exp;
        string rq;
        al  = {a[31:2], 2'b00};
        mw  = mem_at(al);
        exp = ref_merge(k, int'(a[1:0]), mw, r);
        case (k)
            2'b00: rq = "R2";
            2'b01: rq = "R3";
            2'b10: rq = "R4";
            default: rq = "R5";
        endcase
        @(negedge clk);
        chk("R9", "ready before accept", {31'b0, op_ready}, 32'd1);
        op_valid = 1'b1; op_kind = k; op_addr = a; op_reg = r;
        @(negedge clk);
        // R10: operand inputs change after acceptance
        op_valid = poke; op_kind = ~k; op_addr = a ^ 32'h0000_0F07; op_reg = ~r;
        for (int c = 0; c <= rlat; c++) begin
            if (c > 0) @(negedge clk);
            chk("R6", "rd_req held", {31'b0, rd_req}, 32'd1);
            chk("R1", "rd_addr aligned", rd_addr, al);
            chk("R6", "no wr_req during read", {31'b0, wr_req}, 32'd0);
            chk("R9", "busy during read", {31'b0, op_ready}, 32'd0);
            chk("R7", "no reg_we during read", {31'b0, reg_we}, 32'd0);
            if (c == rlat) begin rd_ack = 1'b1; rd_data = mw; end
        end
        @(negedge clk);
        rd_ack = 1'b0; rd_data = 32'hDEAD_BEEF; op_valid = 1'b0;
        if (!k[1]) begin
            chk("R7", "reg_we pulse", {31'b0, reg_we}, 32'd1);
            chk(rq, "load result", reg_wdata, exp);
            chk("R7", "load raises no write", {31'b0, wr_req}, 32'd0);
            chk("R6", "read dropped after ack", {31'b0, rd_req}, 32'd0);
            @(negedge clk);
            chk("R7", "reg_we one cycle", {31'b0, reg_we}, 32'd0);
            chk("R9", "idle after load", {31'b0, op_ready}, 32'd1);
            chk("R9", "no extra read", {31'b0, rd_req}, 32'd0);
        end else begin
            for (int c = 0; c <= wlat; c++) begin
                if (c > 0) @(negedge clk);
                chk("R6", "wr_req held", {31'b0, wr_req}, 32'd1);
                chk("R6", "read not repeated", {31'b0, rd_req}, 32'd0);
                chk("R1", "wr_addr aligned", wr_addr, al);
                chk(rq, "store word", wr_data, exp);
                chk("R9", "busy during write", {31'b0, op_ready}, 32'd0);
                chk("R7", "no reg_we for store", {31'b0, reg_we}, 32'd0);
                if (c == wlat) wr_ack = 1'b1;
            end
            @(negedge clk);
            wr_ack = 1'b0;
            chk("R6", "single write", {31'b0, wr_req}, 32'd0);
            chk("R9", "idle after store", {31'b0, op_ready}, 32'd1);
            chk("R9", "no extra read", {31'b0, rd_req}, 32'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R8", "ready in reset", {31'b0, op_ready}, 32'd1);
        chk("R8", "rd_req in reset", {31'b0, rd_req}, 32'd0);
        chk("R8", "wr_req in reset", {31'b0, wr_req}, 32'd0);
        chk("R8", "reg_we in reset", {31'b0, reg_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8", "ready after reset", {31'b0, op_ready}, 32'd1);
        chk("R8", "idle bus after reset", {30'b0, rd_req, wr_req}, 32'd0);
        // R10: every kind at every offset
        for (int k = 0; k < 4; k++) begin
            for (int o = 0; o < 4; o++) begin
                run_op(2'(k), 32'h1000_0040 + 32'(k * 16) + 32'(o),
                       32'h8122_A344 ^ 32'(k * 32'h0101_0101) ^ 32'(o * 32'h1F00_00E1),
                       (k + o) % 3, o % 2, (o == 2));
            end
        end
        // extremes of address and data
        run_op(2'b00, 32'hFFFF_FFFF, 32'h0000_0000, 0, 0, 1'b0);
        run_op(2'b01, 32'h0000_0000, 32'hFFFF_FFFF, 2, 0, 1'b1);
        run_op(2'b10, 32'h0000_0003, 32'hFFFF_FFFF, 1, 3, 1'b1);
        run_op(2'b11, 32'hFFFF_FFFD, 32'h0123_4567, 0, 2, 1'b0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule